// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset Request

This block is a free-running watchdog counter for a microcontroller-class chip. Once armed, it counts every clock. Software must restart it before the selected interval runs out. When the interval does expire, the block does not reset the chip straight away. It first raises a sticky interrupt flag, so that software gets one last chance to react.

If reset generation is armed and software does not restart the counter, a fixed grace window of clocks follows the flag. At the end of that window the block emits a single-clock reset request to the chip's reset controller. Restarting the counter at any point inside the grace window cancels the pending request.

The two arming bits sit in a small configuration register. A power-on reset clears that register. An ordinary reset, such as one caused by the watchdog's own request, leaves it unchanged.

Top module: `wdog_delayed_reset`

## Requirements
- R1: The enable and reset-arm bits are loaded from `cfg_en_i` and `cfg_rst_en_i` on a clock where `cfg_we_i` is high. `por_i` clears both bits. `rst_i` leaves both bits unchanged.
- R2: While enabled, the counter advances once per clock, and `wd_clear_i` restarts it from zero. `irq_flag_o` rises L clocks after the restart edge. L is 2^(BASE+STEP*sel), where `sel_i` is 0, 1, 2 or 3, so the defaults give 2^17, 2^20, 2^23 and 2^26.
- R3: `irq_flag_o` stays high until a `flag_clear_i` strobe clears it, and `wd_clear_i` has no effect on it. A new expiry on the same clock as the clear strobe wins.
- R4: With reset armed, `rst_req_o` goes high exactly GRACE clocks (default 512) after the edge that set the flag, provided no restart occurs in between.
- R5: `rst_req_o` is high for one clock only. The interval counter and the grace counter both return to zero on that clock.
- R6: A `wd_clear_i` strobe during the grace window cancels the pending request. A later request is timed only from the next expiry.
- R7: With reset not armed, expiry sets the flag and the counter keeps running and wraps, but `rst_req_o` never goes high.
- R8: While the enable bit is low, the counter holds its value, no expiry occurs, and any pending request is dropped.
- R9: A `wd_clear_i` strobe on the same clock as an expiry suppresses that expiry: the flag is not set on that edge.
- R10: `rst_i` or `por_i` zeroes the interval counter, the grace window, the flag and the reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high; also disarms the watchdog |
| rst_i | input | 1 | Ordinary synchronous reset, active high; keeps the arming bits |
| cfg_we_i | input | 1 | Load strobe for the arming bits |
| cfg_en_i | input | 1 | Enable value to load |
| cfg_rst_en_i | input | 1 | Reset-arm value to load |
| sel_i | input | 2 | Interval select, 0 (shortest) to 3 (longest) |
| wd_clear_i | input | 1 | Restart the counter; cancels a pending request |
| flag_clear_i | input | 1 | Clear the interrupt flag |
| irq_flag_o | output | 1 | Sticky expiry interrupt flag |
| rst_req_o | output | 1 | One-clock reset request |

## Verification
The embedded assertions check the following on every cycle:
- the flag holds until its own strobe;
- the reset request lasts a single clock, and only while reset is armed;
- a restart leaves the counter at zero;
- a disabled counter holds still;
- an idle grace counter sits at zero;
- a power-on reset disarms the block.

Only the bench's scenarios can show the exact timing:
- the clock on which the flag rises for each interval select;
- the request landing 512 clocks after the flag;
- the cancellation and re-timing that a mid-window restart causes;
- the suppression of an expiry that coincides with a restart;
- the difference between the two reset inputs.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Arming bits held in the configuration register
    typedef struct packed {
        logic en;
        logic rst_en;
    } wdog_cfg_t;

    // Interval select encoding
    typedef enum logic [1:0] {
        IVL_SHORT  = 2'd0,
        IVL_MID    = 2'd1,
        IVL_LONG   = 2'd2,
        IVL_MAX    = 2'd3
    } wdog_ivl_e;

    localparam int NUM_IVL = 4;

    // Exponent of the interval length for a given select index
    function automatic int ivl_shift(input int base, input int step, input int idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic      clk_i,
    input  logic      por_i,
    input  logic      we_i,
    input  wdog_cfg_t d_i,
    output wdog_cfg_t q_o
);

    wdog_cfg_t cfg_q;

    // Only a power-on reset clears the arming bits
    always_ff @(posedge clk_i) begin
        if (por_i)
            cfg_q <= '0;
        else if (we_i)
            cfg_q <= d_i;
    end

    assign q_o = cfg_q;

    AST_POR_DISARM: assert property (@(posedge clk_i)
        por_i |=> (q_o == '0)); // R1

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
    import wdog_pkg::*;
#(
    parameter int BASE  = 17,
    parameter int STEP  = 3,
    parameter int CNT_W = BASE + STEP * (NUM_IVL - 1)
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      en_i,
    input  logic      restart_i,
    input  wdog_ivl_e sel_i,
    output logic      tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask_tab [NUM_IVL];
    logic [CNT_W-1:0] mask;

    // One low-bit mask per interval select
    for (genvar i = 0; i < NUM_IVL; i++) begin : g_mask
        localparam int SH = ivl_shift(BASE, STEP, i);
        assign mask_tab[i] = {CNT_W{1'b1}} >> (CNT_W - SH);
    end

    assign mask = mask_tab[sel_i];

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i)
            cnt_q <= '0;
        else if (en_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Expiry when the selected low bits are all ones; a restart takes precedence
    assign tick_o = en_i && !restart_i && ((cnt_q & mask) == mask);

    AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> (cnt_q == '0)); // R2

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !restart_i) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/wdog_grace.sv
module wdog_grace #(
    parameter int GRACE = 512,
    parameter int GW    = $clog2(GRACE)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic cancel_i,
    output logic fire_o,
    output logic pending_o
);

    localparam logic [GW-1:0] LAST = GW'(GRACE - 1);

    logic          pend_q;
    logic [GW-1:0] gcnt_q;

    assign fire_o    = pend_q && (gcnt_q == LAST);
    assign pending_o = pend_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || cancel_i || fire_o) begin
            pend_q <= 1'b0;
            gcnt_q <= '0;
        end else if (pend_q) begin
            gcnt_q <= gcnt_q + 1'b1;
        end else if (start_i) begin
            pend_q <= 1'b1;
            gcnt_q <= '0;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !pend_q |-> (gcnt_q == '0)); // R5

    AST_CANCEL_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        cancel_i |=> !pend_q); // R6

endmodule

// File: rtl/wdog_delayed_reset.sv
module wdog_delayed_reset
    import wdog_pkg::*;
#(
    parameter int BASE  = 17,
    parameter int STEP  = 3,
    parameter int GRACE = 512
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       rst_i,
    input  logic       cfg_we_i,
    input  logic       cfg_en_i,
    input  logic       cfg_rst_en_i,
    input  logic [1:0] sel_i,
    input  logic       wd_clear_i,
    input  logic       flag_clear_i,
    output logic       irq_flag_o,
    output logic       rst_req_o
);

    localparam int CNT_W = BASE + STEP * (NUM_IVL - 1);

    wdog_cfg_t cfg_d, cfg_q;
    logic      rst_any;
    logic      tick, fire, pending, restart, cancel;
    logic      flag_q, req_q;

    assign rst_any = rst_i || por_i;
    assign cfg_d   = '{en: cfg_en_i, rst_en: cfg_rst_en_i};

    wdog_cfg_reg u_cfg (
        .clk_i (clk_i),
        .por_i (por_i),
        .we_i  (cfg_we_i),
        .d_i   (cfg_d),
        .q_o   (cfg_q)
    );

    // A fired request also restarts the interval counter
    assign restart = wd_clear_i || fire;

    wdog_tick_counter #(
        .BASE  (BASE),
        .STEP  (STEP),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_any),
        .en_i      (cfg_q.en),
        .restart_i (restart),
        .sel_i     (wdog_ivl_e'(sel_i)),
        .tick_o    (tick)
    );

    assign cancel = wd_clear_i || !cfg_q.en || !cfg_q.rst_en;

    wdog_grace #(
        .GRACE (GRACE)
    ) u_grace (
        .clk_i     (clk_i),
        .rst_i     (rst_any),
        .start_i   (tick && cfg_q.rst_en),
        .cancel_i  (cancel),
        .fire_o    (fire),
        .pending_o (pending)
    );

    always_ff @(posedge clk_i) begin
        if (rst_any) begin
            flag_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= fire;
            if (tick)
                flag_q <= 1'b1;
            else if (flag_clear_i)
                flag_q <= 1'b0;
        end
    end

    assign irq_flag_o = flag_q;
    assign rst_req_o  = req_q;

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (rst_any)
        (irq_flag_o && !flag_clear_i) |=> irq_flag_o); // R3

    AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (rst_any)
        rst_req_o |=> !rst_req_o); // R5

    AST_REQ_ARMED: assert property (@(posedge clk_i) disable iff (rst_any)
        rst_req_o |-> $past(cfg_q.rst_en && cfg_q.en)); // R4 R7

    AST_NO_PEND_UNARMED: assert property (@(posedge clk_i) disable iff (rst_any)
        !cfg_q.rst_en |=> !pending); // R7

endmodule

// File: tb/wdog_delayed_reset_bench.sv
module wdog_delayed_reset_bench;

    // Small intervals: 16, 64, 256, 1024 clocks; grace kept at 512
    localparam int BASE  = 4;
    localparam int STEP  = 2;
    localparam int GRACE = 512;

    logic       clk = 1'b0;
    logic       por = 1'b1, rst = 1'b0;
    logic       cfg_we = 1'b0, cfg_en = 1'b0, cfg_rst_en = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       wd_clear = 1'b0, flag_clear = 1'b0;
    logic       irq_flag, rst_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wdog_delayed_reset #(.BASE(BASE), .STEP(STEP), .GRACE(GRACE)) u_wdog_delayed_reset (
        .clk_i        (clk),
        .por_i        (por),
        .rst_i        (rst),
        .cfg_we_i     (cfg_we),
        .cfg_en_i     (cfg_en),
        .cfg_rst_en_i (cfg_rst_en),
        .sel_i        (sel),
        .wd_clear_i   (wd_clear),
        .flag_clear_i (flag_clear),
        .irq_flag_o   (irq_flag),
        .rst_req_o    (rst_req)
    );

    // Fields: sel(2) rst_en(1) clear_edge(12, 0 = none) flag_edge(12) req_edge(12, 0 = none) run(12)
    localparam int VW = 51;
    localparam int NV = 7;
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 1'b1, 12'd0,   12'd16,   12'd528,  12'd600},  // R2 R4 R5
        {2'd1, 1'b1, 12'd0,   12'd64,   12'd576,  12'd650},  // R2 R4
        {2'd2, 1'b1, 12'd0,   12'd256,  12'd768,  12'd800},  // R2 R4
        {2'd3, 1'b1, 12'd0,   12'd1024, 12'd1536, 12'd1600}, // R2 R4
        {2'd1, 1'b0, 12'd0,   12'd64,   12'd0,    12'd700},  // R7
        {2'd1, 1'b1, 12'd40,  12'd104,  12'd616,  12'd700},  // R2 restart
        {2'd0, 1'b1, 12'd100, 12'd16,   12'd628,  12'd700}   // R6
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive strobes for the next edge, then return at the following negedge
    task automatic step(input logic c, input logic f);
        wd_clear   = c;
        flag_clear = f;
        @(negedge clk);
        wd_clear   = 1'b0;
        flag_clear = 1'b0;
    endtask

    // Ordinary reset (optionally loading config), then a restart on edge 0
    task automatic start(input logic [1:0] s, input logic en, input logic re, input logic wr);
        rst        = 1'b1;
        cfg_we     = wr;
        cfg_en     = en;
        cfg_rst_en = re;
        sel        = s;
        @(negedge clk);
        rst    = 1'b0;
        cfg_we = 1'b0;
        step(1'b1, 1'b0);
    endtask

    task automatic run_steps(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10: reset state
        check("R10 flag after por", int'(irq_flag), 0);
        check("R10 req after por", int'(rst_req), 0);
        por = 1'b0;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            int clr_at, exp_flag, exp_req, run;
            int first_flag, first_req, req_cnt;
            e        = VEC[v];
            clr_at   = int'(e[47:36]);
            exp_flag = int'(e[35:24]);
            exp_req  = int'(e[23:12]);
            run      = int'(e[11:0]);
            first_flag = 0;
            first_req  = 0;
            req_cnt    = 0;
            start(e[50:49], 1'b1, e[48], 1'b1);
            for (int n = 1; n <= run; n++) begin
                step(n == clr_at, 1'b0);
                if (irq_flag && first_flag == 0) first_flag = n;
                if (rst_req) begin
                    req_cnt++;
                    if (first_req == 0) first_req = n;
                end
            end
            check($sformatf("R2 flag edge vec%0d", v), first_flag, exp_flag);
            check($sformatf("R4 R6 R7 req edge vec%0d", v), first_req, exp_req);
            check($sformatf("R5 req width vec%0d", v), req_cnt, (exp_req != 0) ? 1 : 0);
        end

        // R1: power-on reset disarms; ordinary reset keeps arming
        start(2'd0, 1'b1, 1'b1, 1'b1);
        por = 1'b1;
        @(negedge clk);
        por = 1'b0;
        start(2'd0, 1'b0, 1'b0, 1'b0);
        run_steps(40);
        check("R1 por disarms", int'(irq_flag), 0);
        start(2'd0, 1'b1, 1'b1, 1'b1);
        start(2'd0, 1'b0, 1'b0, 1'b0);
        run_steps(16);
        check("R1 rst keeps arm", int'(irq_flag), 1);

        // R3: flag survives counter restart, falls on its own strobe
        step(1'b1, 1'b0);
        check("R3 flag after wd_clear", int'(irq_flag), 1);
        step(1'b0, 1'b1);
        check("R3 flag after flag_clear", int'(irq_flag), 0);

        // R8: disabled block never expires
        start(2'd0, 1'b0, 1'b1, 1'b1);
        run_steps(100);
        check("R8 flag when disabled", int'(irq_flag), 0);

        // R9: restart coinciding with expiry suppresses it
        start(2'd0, 1'b1, 1'b0, 1'b1);
        run_steps(15);
        step(1'b1, 1'b0);
        check("R9 no flag at coinciding edge", int'(irq_flag), 0);
        run_steps(15);
        check("R9 flag before next expiry", int'(irq_flag), 0);
        step(1'b0, 1'b0);
        check("R9 flag at next expiry", int'(irq_flag), 1);

        // R10: ordinary reset drops flag and pending request
        start(2'd0, 1'b1, 1'b1, 1'b1);
        run_steps(20);
        start(2'd0, 1'b0, 1'b0, 1'b0);
        check("R10 flag cleared by rst", int'(irq_flag), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule